// File: doc/BRIEF.md
# Hit multiplicity trigger generator

The block watches a bank of single-bit counter hit lines, sampled on the system clock. Every channel passes through its own programmable delay and is then stretched to a programmable number of cycles, so that hits arriving with small timing skews line up. The stretched channels are scanned for clusters. A cluster is a maximal run of neighbouring active channels. The number of clusters is compared with a programmable multiplicity threshold.

When the threshold is reached and no trigger is already in progress, the block fires a Level-0 pulse and a Hold pulse, and each pulse has its own programmable width. A busy flag covers the time from the start of a trigger until both pulses have ended. While busy is high, new trigger conditions are ignored. The registered cluster count is brought out as a monitor, and so are the L0, Hold and busy bits.

With no delay programmed, L0 rises two clocks after the hit is sampled. At a 64 MHz clock this is about 31 ns, which keeps the path inside a 50 ns budget. The channel count is a parameter, so the block can grow from 32 channels to 64 or 128.

Top module: `hit_mult_trig`

## Requirements
- R1: A hit sampled at clock edge E0 on a channel with delay d (0..7, field `cfg_dly[3*i+:3]`) starts that channel's stretched pulse at edge E1+d. A trigger it causes raises L0 and Hold together at edge E2+d. Each channel's delay is independent of the others.
- R2: A stretched pulse lasts w cycles, where w is given by field `cfg_wid[3*i+:3]`. Values 0 and 1 act as 2. A rising edge of the delayed hit reloads the pulse.
- R3: `mon_clu` holds, one clock after the stretched hits, the number of maximal runs of adjacent active channels. Channel 0 and the last channel are not adjacent. The value is 0 when no channel is active.
- R4: The cluster count saturates at 7.
- R5: A trigger fires when the count is at least `cfg_thr`. A `cfg_thr` of 0 selects the default threshold of 2.
- R6: L0 stays high for `cfg_l0_wid` cycles and Hold for `cfg_hold_wid` cycles, where a width of 0 acts as 1.
- R7: L0 and Hold start in the same cycle. Busy is high from that cycle until both pulses have ended.
- R8: A trigger condition that occurs while busy is high produces no L0 or Hold. The cluster count is still updated.
- R9: An active-low asynchronous reset clears L0, Hold, busy and the cluster count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low (combined reset sources) |
| hit_in | input | NCH | Hit lines, one per channel |
| cfg_dly | input | NCH*3 | Per-channel delay, 3 bits per channel |
| cfg_wid | input | NCH*3 | Per-channel stretch width, 3 bits per channel |
| cfg_thr | input | 3 | Multiplicity threshold (0 means 2) |
| cfg_l0_wid | input | 4 | L0 pulse width in cycles (0 means 1) |
| cfg_hold_wid | input | 4 | Hold pulse width in cycles (0 means 1) |
| l0_out | output | 1 | Level-0 trigger pulse |
| hold_out | output | 1 | Hold pulse |
| busy_out | output | 1 | Trigger in progress |
| mon_clu | output | 3 | Registered, saturated cluster count |

## Verification
The bench targets how clusters are formed and where they end. Neighbouring hits must count as one cluster. Hits on channel 0 and on the last channel must count as two, and a design that wrapped the channel index would count them as one. A pattern of sixteen isolated hits shows whether the count saturates at 7 or wraps to a small value. A threshold of 0 must behave as 2 and not fire on every empty cycle.

Timing is checked by probing for L0 one cycle before and one cycle at its expected edge. A design with an off-by-one delay tap or stretch counter misses one of these probes. Two channels delayed so that their stretched pulses never overlap must produce no trigger.

A second hit is sent while Hold is still active. A design that did not gate on busy would emit a second L0 there. Reset is asserted in the middle of a pulse, and all outputs must clear at once.

// File: rtl/hit_mult_trig.sv
module hit_mult_trig #(
  parameter int NCH = 32,
  parameter int DW  = 3,
  parameter int WW  = 3,
  parameter int PW  = 4,
  parameter int CW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    hit_in,
  input  logic [NCH*DW-1:0] cfg_dly,
  input  logic [NCH*WW-1:0] cfg_wid,
  input  logic [CW-1:0]     cfg_thr,
  input  logic [PW-1:0]     cfg_l0_wid,
  input  logic [PW-1:0]     cfg_hold_wid,
  output logic              l0_out,
  output logic              hold_out,
  output logic              busy_out,
  output logic [CW-1:0]     mon_clu
);
  localparam int TAPS = (1 << DW) - 1;
  localparam int CMAX = (1 << CW) - 1;
  localparam int SW   = $clog2(NCH + 1);

  logic [NCH-1:0]  hit_q, tap, tap_d, str, starts;
  logic [TAPS-1:0] sreg [NCH];
  logic [WW-1:0]   scnt [NCH];
  logic [SW-1:0]   nsum;
  logic [CW-1:0]   clu_next, eff_thr;
  logic [PW-1:0]   l0_cnt, hold_cnt;
  logic            fire;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (cfg_dly[i*DW +: DW] == '0) tap[i] = hit_q[i];
      else                           tap[i] = sreg[i][cfg_dly[i*DW +: DW] - 1'b1];
      str[i] = (scnt[i] != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      tap_d <= '0;
      for (int i = 0; i < NCH; i++) begin
        sreg[i] <= '0;
        scnt[i] <= '0;
      end
    end else begin
      hit_q <= hit_in;
      tap_d <= tap;
      for (int i = 0; i < NCH; i++) begin
        sreg[i] <= (sreg[i] << 1) | TAPS'(hit_q[i]);
        if (tap[i] && !tap_d[i])
          scnt[i] <= (cfg_wid[i*WW +: WW] < WW'(2)) ? WW'(2) : cfg_wid[i*WW +: WW];
        else if (scnt[i] != '0)
          scnt[i] <= scnt[i] - 1'b1;
      end
    end
  end

  assign starts = str & ~{str[NCH-2:0], 1'b0};

  always_comb begin
    nsum = '0;
    for (int i = 0; i < NCH; i++) nsum = nsum + SW'(starts[i]);
  end

  assign clu_next = (nsum > SW'(CMAX)) ? CW'(CMAX) : nsum[CW-1:0];
  assign eff_thr  = (cfg_thr == '0) ? CW'(2) : cfg_thr;
  assign fire     = (clu_next >= eff_thr) && !busy_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_clu  <= '0;
      l0_cnt   <= '0;
      hold_cnt <= '0;
    end else begin
      mon_clu <= clu_next;
      if (fire) begin
        l0_cnt   <= (cfg_l0_wid == '0)   ? PW'(1) : cfg_l0_wid;
        hold_cnt <= (cfg_hold_wid == '0) ? PW'(1) : cfg_hold_wid;
      end else begin
        if (l0_cnt != '0)   l0_cnt   <= l0_cnt - 1'b1;
        if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end

  assign l0_out   = (l0_cnt != '0);
  assign hold_out = (hold_cnt != '0);
  assign busy_out = l0_out | hold_out;

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_STRETCH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(str[g]) |=> str[g]); // R2
  end

  AST_CLU_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (str == '0) |=> (mon_clu == '0)); // R3
  AST_THR_MET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l0_out) |-> (mon_clu >= $past(eff_thr))); // R5
  AST_PAIR_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l0_out) |-> $rose(hold_out)); // R7
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l0_out) |-> !$past(busy_out)); // R8
endmodule

// File: tb/sim_hit_mult_trig.sv
module sim_hit_mult_trig;
  localparam int NCH = 32;
  localparam int NV  = 11;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0]   hit_in = '0;
  logic [NCH*3-1:0] cfg_dly = '0, cfg_wid = '0;
  logic [2:0]       cfg_thr = 3'd2;
  logic [3:0]       cfg_l0_wid = 4'd3, cfg_hold_wid = 4'd5;
  logic l0_out, hold_out, busy_out;
  logic [2:0] mon_clu;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  hit_mult_trig u0 (.clk(clk), .rst_n(rst_n), .hit_in(hit_in), .cfg_dly(cfg_dly),
    .cfg_wid(cfg_wid), .cfg_thr(cfg_thr), .cfg_l0_wid(cfg_l0_wid),
    .cfg_hold_wid(cfg_hold_wid), .l0_out(l0_out), .hold_out(hold_out),
    .busy_out(busy_out), .mon_clu(mon_clu));

  localparam logic [31:0] V_PAT [NV] = '{32'h0000_0001, 32'h0000_0005, 32'h0000_0003,
    32'h8000_0001, 32'h5555_5555, 32'h0F0F_0000, 32'h0000_0111, 32'h0000_0111,
    32'hFFFF_FFFF, 32'h0000_0000, 32'h00F0_00F1};
  localparam int V_THR  [NV] = '{2, 2, 2, 2, 2, 0, 3, 4, 1, 1, 7};
  localparam int V_CLU  [NV] = '{1, 2, 1, 2, 7, 2, 3, 3, 1, 0, 3};
  localparam int V_FIRE [NV] = '{0, 1, 0, 1, 1, 1, 1, 0, 1, 0, 0};

  task automatic chk(input int act, input int exp, input string msg);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", msg, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] pat);
    @(negedge clk) hit_in = pat;
    @(negedge clk) hit_in = '0;
  endtask

  task automatic set_all(input int d, input int w);
    for (int i = 0; i < NCH; i++) begin
      cfg_dly[i*3 +: 3] = 3'(d);
      cfg_wid[i*3 +: 3] = 3'(w);
    end
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_all(0, 2);
    step(3);
    chk(l0_out, 0, "R9 reset l0");
    chk(hold_out, 0, "R9 reset hold");
    chk(busy_out, 0, "R9 reset busy");
    chk(mon_clu, 0, "R9 reset clu");
    rst_n = 1;
    step(2);

    for (int v = 0; v < NV; v++) begin
      cfg_thr = 3'(V_THR[v]);
      send(V_PAT[v]);
      step(2);
      chk(mon_clu, V_CLU[v], $sformatf("R3/R4 vec%0d clusters", v));
      chk(l0_out, V_FIRE[v], $sformatf("R5 vec%0d l0", v));
      chk(hold_out, V_FIRE[v], $sformatf("R7 vec%0d hold", v));
      step(20);
    end

    // R1 delay of 3 cycles on all channels
    cfg_thr = 3'd2; set_all(3, 2);
    send(32'h5); step(4);
    chk(l0_out, 0, "R1 delay3 l0 before edge");
    step(1);
    chk(l0_out, 1, "R1 delay3 l0 at edge");
    chk(hold_out, 1, "R1 delay3 hold at edge");
    step(20);

    // R1 independent per-channel delay: pulses never overlap
    set_all(0, 2); cfg_dly[2*3 +: 3] = 3'd2;
    send(32'h5); step(2);
    chk(mon_clu, 1, "R1 skewed ch0 cluster");
    for (int k = 0; k < 5; k++) begin
      chk(l0_out, 0, "R1 skewed no trigger");
      if (k == 1) chk(mon_clu, 1, "R1 skewed ch2 cluster");
      step(1);
    end
    step(20);

    // R2 stretch width 5, no trigger at threshold 7
    set_all(0, 5); cfg_thr = 3'd7;
    send(32'h1); step(2);
    chk(mon_clu, 1, "R2 width5 first");
    step(4);
    chk(mon_clu, 1, "R2 width5 last");
    step(1);
    chk(mon_clu, 0, "R2 width5 ended");
    step(10);

    // R2 width 0 acts as 2
    set_all(0, 0);
    send(32'h1); step(3);
    chk(mon_clu, 1, "R2 width0 second cycle");
    step(1);
    chk(mon_clu, 0, "R2 width0 ended");
    step(10);

    // R6/R7 pulse widths
    set_all(0, 2); cfg_thr = 3'd2; cfg_l0_wid = 4'd3; cfg_hold_wid = 4'd5;
    send(32'h5); step(2);
    chk(busy_out, 1, "R7 busy at start");
    step(2);
    chk(l0_out, 1, "R6 l0 third cycle");
    step(1);
    chk(l0_out, 0, "R6 l0 ended");
    chk(busy_out, 1, "R7 busy while hold");
    step(1);
    chk(hold_out, 1, "R6 hold fifth cycle");
    step(1);
    chk(hold_out, 0, "R6 hold ended");
    chk(busy_out, 0, "R7 busy ended");
    step(10);

    // R6 width 0 acts as 1
    cfg_l0_wid = 4'd0;
    send(32'h5); step(2);
    chk(l0_out, 1, "R6 l0 width0 high");
    step(1);
    chk(l0_out, 0, "R6 l0 width0 one cycle");
    chk(hold_out, 1, "R6 hold continues");
    step(10);

    // R8 trigger ignored while busy
    cfg_l0_wid = 4'd3; cfg_hold_wid = 4'd8;
    send(32'h5); step(2);
    chk(l0_out, 1, "R8 first trigger");
    send(32'h5); step(2);
    chk(l0_out, 0, "R8 no second l0");
    chk(hold_out, 1, "R8 hold still first");
    chk(mon_clu, 2, "R8 clusters still counted");
    step(6);
    chk(busy_out, 0, "R8 busy released");
    chk(l0_out, 0, "R8 no late trigger");
    step(10);

    // R9 reset in the middle of a trigger
    send(32'h5); step(2);
    chk(l0_out, 1, "R9 pre-reset l0");
    rst_n = 0;
    step(1);
    chk(l0_out, 0, "R9 mid reset l0");
    chk(hold_out, 0, "R9 mid reset hold");
    chk(busy_out, 0, "R9 mid reset busy");
    chk(mon_clu, 0, "R9 mid reset clu");
    rst_n = 1;
    step(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule